// File: doc/BRIEF.md
# PWM Timer with Deferred Duty Reload

An up-counting timer that drives a pulse-width-modulated output. One compare value sets the period: when the counter reaches it, the counter returns to zero, the output goes to its active level and a one-clock interrupt pulse is raised. A second compare value sets the duty point: when the counter reaches it, the output drops to its inactive level. The counter is not cleared at that point and no interrupt is raised.

The timer advances only on a count strobe, a single-cycle enable inside the system clock domain. While the timer is running, new period and duty values are held in pending buffers so the waveform never glitches. A pending period value is loaded at the next period match. A pending duty value is loaded only at a match against the old duty value, and only if that write is at least three count strobes old. While the timer is stopped, writes take effect at once.

Top module: `pwm_duty_timer`

## Requirements
- R1: After reset the interrupt output is 0 and the PWM output is at the inactive level. The period compare value resets to FFh and the duty compare value to 00h.
- R2: On a 0-to-1 change of the enable, the counter starts from 00h. The first count strobe after enable does not increment the counter, and the output stays inactive until the first period match.
- R3: On a count strobe where the counter equals the period compare value, the counter returns to 00h, the output goes active and the interrupt is high for exactly the following system clock cycle. A period match takes priority over a duty match on the same count.
- R4: On a count strobe where the counter equals the active duty compare value (and not the period value), the output goes inactive, the counter keeps incrementing and no interrupt is raised.
- R5: A duty write while enabled goes only to a pending buffer and does not alter the active duty value until a transfer.
- R6: A pending duty value is loaded at a duty match against the old active value; that same match still drives the output inactive.
- R7: At a duty match, the transfer happens only if the matching strobe is at least the third count strobe after the write. Otherwise the value stays pending for a later duty match.
- R8: A duty write while a value is pending replaces it and restarts the age count.
- R9: With enable low, the output is inactive, the interrupt is low and the counter is held at 00h. A period or duty write while disabled, or any pending value, takes effect directly.
- R10: The polarity input set to 0 makes the active level high; set to 1 it makes the active level low.
- R11: A period write while enabled is taken at the next period match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Count strobe, one system cycle wide |
| tmr_en | input | 1 | Timer enable |
| period_wr | input | 1 | Period write strobe |
| period_data | input | 8 | Period write value |
| duty_wr | input | 1 | Duty write strobe |
| duty_data | input | 8 | Duty write value |
| out_pol | input | 1 | Active level select (0 = high active) |
| pwm_out | output | 1 | PWM waveform |
| irq_pulse | output | 1 | Period match interrupt pulse |

## Verification
Directed phases use a steady strobe on every cycle, with short periods, so the masked first strobe and the period and duty edges fall on predictable counts. Duty writes placed one, two and three strobes before a duty match separate a skipped transfer from a taken one. Back-to-back rewrites test the replacement and the age restart. A long random phase mixes sparse strobes, enable drops, polarity flips and period changes, some of them to values below the duty point, so the interplay of buffering with stop and restart is exercised.

// File: rtl/pwm_tmr_pkg.sv
// Package: types shared by the PWM timer modules.
package pwm_tmr_pkg;
    // Counter phase: waiting for the masked first strobe, or counting.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Compare events produced on a count strobe.
    typedef struct packed {
        logic period_hit;
        logic duty_hit;
    } hit_t;
endpackage

// File: rtl/pwm_tmr_counter.sv
// Module: pwm_tmr_counter
// Up counter with a masked first strobe and compare logic.
// Assumes tick is a one-cycle strobe in the clk domain. The period
// compare has priority over the duty compare on the same count.
module pwm_tmr_counter
    import pwm_tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] period_act,
    input  logic [W-1:0] duty_act,
    output hit_t         hits
);
    phase_e       phase_q;
    logic [W-1:0] cnt_q;
    logic         run_tick;

    // Purpose: a strobe that counts (the first one after enable is masked).
    assign run_tick = en && tick && (phase_q == PH_RUN);

    // Purpose: decode period and duty matches on counting strobes.
    always_comb begin
        hits.period_hit = run_tick && (cnt_q == period_act);
        hits.duty_hit   = run_tick && (cnt_q != period_act) && (cnt_q == duty_act);
    end

    // Purpose: phase tracking and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (!en) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (tick) begin
            if (phase_q == PH_IDLE) begin
                phase_q <= PH_RUN;
            end else if (hits.period_hit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_tmr_cmp_reg.sv
// Module: pwm_tmr_cmp_reg
// Compare register with a pending buffer. While enabled, a write goes
// to the pending buffer and is loaded into the active value on 'take'.
// With USE_AGE set, the load also needs the take strobe to be at least
// MIN_AGE strobes after the write. While disabled, writes and pending
// values go straight to the active value.
module pwm_tmr_cmp_reg #(
    parameter int          W       = 8,
    parameter int          MIN_AGE = 3,
    parameter bit          USE_AGE = 1'b1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic [W-1:0] act
);
    localparam int AW = $clog2(MIN_AGE + 1);
    localparam logic [AW-1:0] AGE_SAT = AW'(MIN_AGE);

    logic [W-1:0]  act_q;
    logic [W-1:0]  pend_q;
    logic          pend_v_q;
    logic [AW-1:0] age_q;
    logic          age_ok;

    // Purpose: choose whether the age rule gates the transfer.
    generate
        if (USE_AGE) begin : g_aged
            assign age_ok = (int'(age_q) + 1) >= MIN_AGE;
        end else begin : g_free
            assign age_ok = 1'b1;
        end
    endgenerate

    // Purpose: track strobes since the last write, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || wr) begin
            age_q <= '0;
        end else if (tick && (age_q < AGE_SAT)) begin
            age_q <= age_q + 1'b1;
        end
    end

    // Purpose: pending buffer and active value update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= RST_VAL;
            pend_q   <= RST_VAL;
            pend_v_q <= 1'b0;
        end else if (!en) begin
            if (wr) begin
                act_q <= wdata;
            end else if (pend_v_q) begin
                act_q <= pend_q;
            end
            pend_v_q <= 1'b0;
        end else if (wr) begin
            pend_q   <= wdata;
            pend_v_q <= 1'b1;
        end else if (take && pend_v_q && age_ok) begin
            act_q    <= pend_q;
            pend_v_q <= 1'b0;
        end
    end

    assign act = act_q;
endmodule

// File: rtl/pwm_tmr_output.sv
// Module: pwm_tmr_output
// Output level flag, polarity and interrupt pulse. The output goes
// active at a period match and inactive at a duty match or when disabled.
module pwm_tmr_output
    import pwm_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  hit_t hits,
    input  logic pol,
    output logic pwm,
    output logic irq
);
    logic act_q;
    logic irq_q;

    // Purpose: active or inactive state of the waveform.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            act_q <= 1'b0;
        end else if (hits.period_hit) begin
            act_q <= 1'b1;
        end else if (hits.duty_hit) begin
            act_q <= 1'b0;
        end
    end

    // Purpose: one-cycle interrupt after a period match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= en && hits.period_hit;
        end
    end

    assign pwm = act_q ^ pol;
    assign irq = irq_q;
endmodule

// File: rtl/pwm_duty_timer.sv
// Module: pwm_duty_timer (top)
// PWM timer with buffered period and age-gated buffered duty. All
// logic runs on clk; cnt_tick is the count strobe.
module pwm_duty_timer
    import pwm_tmr_pkg::*;
#(
    parameter int           W          = 8,
    parameter int           MIN_AGE    = 3,
    parameter logic [W-1:0] RST_PERIOD = '1,
    parameter logic [W-1:0] RST_DUTY   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_tick,
    input  logic         tmr_en,
    input  logic         period_wr,
    input  logic [W-1:0] period_data,
    input  logic         duty_wr,
    input  logic [W-1:0] duty_data,
    input  logic         out_pol,
    output logic         pwm_out,
    output logic         irq_pulse
);
    hit_t         hits_w;
    logic [W-1:0] period_act_w;
    logic [W-1:0] duty_act_w;

    pwm_tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(tmr_en), .tick(cnt_tick),
        .period_act(period_act_w), .duty_act(duty_act_w), .hits(hits_w)
    );

    pwm_tmr_cmp_reg #(.W(W), .MIN_AGE(MIN_AGE), .USE_AGE(1'b0), .RST_VAL(RST_PERIOD)) u_period (
        .clk(clk), .rst_n(rst_n), .en(tmr_en), .tick(cnt_tick),
        .wr(period_wr), .wdata(period_data), .take(hits_w.period_hit), .act(period_act_w)
    );

    pwm_tmr_cmp_reg #(.W(W), .MIN_AGE(MIN_AGE), .USE_AGE(1'b1), .RST_VAL(RST_DUTY)) u_duty (
        .clk(clk), .rst_n(rst_n), .en(tmr_en), .tick(cnt_tick),
        .wr(duty_wr), .wdata(duty_data), .take(hits_w.duty_hit), .act(duty_act_w)
    );

    pwm_tmr_output u_out (
        .clk(clk), .rst_n(rst_n), .en(tmr_en), .hits(hits_w),
        .pol(out_pol), .pwm(pwm_out), .irq(irq_pulse)
    );
endmodule

// File: rtl/pwm_duty_timer_chk.sv
// Module: pwm_duty_timer_chk
// Temporal checks on the timer, bound into the top module.
module pwm_duty_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_tick,
    input logic         tmr_en,
    input logic         out_pol,
    input logic         pwm_out,
    input logic         irq_pulse,
    input logic [W-1:0] duty_act
);
    // R3: an interrupt only follows an enabled count strobe.
    a_r3_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(cnt_tick) && $past(tmr_en)));

    // R4: without a strobe, the waveform level does not move.
    a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && !cnt_tick) |=> $stable(pwm_out ^ out_pol));

    // R5: the active duty value only changes on a strobe while enabled.
    a_r5_duty_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && !cnt_tick) |=> $stable(duty_act));

    // R9: disabled means inactive level and no interrupt.
    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> ((pwm_out == out_pol) && !irq_pulse));
endmodule

bind pwm_duty_timer pwm_duty_timer_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .tmr_en(tmr_en),
    .out_pol(out_pol), .pwm_out(pwm_out), .irq_pulse(irq_pulse),
    .duty_act(duty_act_w)
);

// File: tb/tb_pwm_duty_timer.sv
// Bench for pwm_duty_timer: directed corners plus seeded random stimulus,
// compared every cycle against a bench-side behavioural model.
module tb_pwm_duty_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       tmr_en = 1'b0;
    logic       period_wr = 1'b0;
    logic [7:0] period_data = '0;
    logic       duty_wr = 1'b0;
    logic [7:0] duty_data = '0;
    logic       out_pol = 1'b0;
    logic       pwm_out;
    logic       irq_pulse;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // model state
    bit       m_run, m_out, m_irq, m_ppv, m_dpv, m_repl;
    bit [7:0] m_cnt, m_pact, m_ppend, m_dact, m_dpend;
    int       m_age;
    string    m_tag = "R1";
    string    m_itag = "R1";

    always #2 clk = ~clk;

    pwm_duty_timer dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .tmr_en(tmr_en),
        .period_wr(period_wr), .period_data(period_data),
        .duty_wr(duty_wr), .duty_data(duty_data), .out_pol(out_pol),
        .pwm_out(pwm_out), .irq_pulse(irq_pulse)
    );

    function automatic bit exp_level(input bit active, input bit pol);
        return active ^ pol; // R10: pol 1 inverts the levels
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_outputs();
        string t;
        t = out_pol ? {m_tag, "/R10"} : m_tag;
        check(t, "pwm_out", pwm_out, exp_level(m_out, out_pol));
        check(m_itag, "irq_pulse", irq_pulse, m_irq);
    endtask

    // Behavioural model: next state after a clock edge with given inputs.
    task automatic model_step();
        bit p_hit, d_hit;
        if (!rst_n) begin
            m_run = 0; m_out = 0; m_irq = 0; m_cnt = 0;
            m_pact = 8'hFF; m_ppend = 8'hFF; m_ppv = 0;
            m_dact = 8'h00; m_dpend = 8'h00; m_dpv = 0; m_age = 0; m_repl = 0;
            m_tag = "R1"; m_itag = "R1";
            return;
        end
        if (!tmr_en) begin
            m_run = 0; m_out = 0; m_irq = 0; m_cnt = 0;
            if (period_wr) m_pact = period_data; else if (m_ppv) m_pact = m_ppend;
            if (duty_wr) m_dact = duty_data; else if (m_dpv) m_dact = m_dpend;
            m_ppv = 0; m_dpv = 0; m_age = 0; m_repl = 0;
            m_tag = "R9"; m_itag = "R9";
            return;
        end
        p_hit = m_run && cnt_tick && (m_cnt == m_pact);
        d_hit = m_run && cnt_tick && !p_hit && (m_cnt == m_dact);
        m_irq = p_hit;
        m_itag = p_hit ? "R3" : "R4";
        if (!m_run && cnt_tick) begin
            m_run = 1; m_tag = "R2";
        end else if (p_hit) begin
            m_cnt = 0; m_out = 1; m_tag = "R3";
        end else if (m_run && cnt_tick) begin
            m_cnt = m_cnt + 8'd1;
            if (d_hit) begin m_out = 0; m_tag = "R4"; end
        end
        if (period_wr) begin
            m_ppend = period_data; m_ppv = 1;
        end else if (p_hit && m_ppv) begin
            m_pact = m_ppend; m_ppv = 0; m_tag = "R11";
        end
        if (duty_wr) begin
            m_repl = m_dpv; m_dpend = duty_data; m_dpv = 1; m_age = 0;
            if (m_tag != "R3") m_tag = "R5";
        end else begin
            if (d_hit && m_dpv) begin
                if (m_age + 1 >= 3) begin
                    m_dact = m_dpend; m_dpv = 0;
                    m_tag = m_repl ? "R8" : "R6";
                    m_repl = 0;
                end else begin
                    m_tag = "R7";
                end
            end
            if (cnt_tick && m_age < 3) m_age++;
        end
    endtask

    // One system cycle: compare, apply inputs, advance model.
    task automatic cyc(input bit t, input bit en, input bit pw, input bit [7:0] pd,
                       input bit dw, input bit [7:0] dd, input bit pl);
        @(negedge clk);
        compare_outputs();
        cnt_tick = t; tmr_en = en; period_wr = pw; period_data = pd;
        duty_wr = dw; duty_data = dd; out_pol = pl;
        model_step();
    endtask

    task automatic run_ticks(input int n, input bit pl);
        for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, 0, 0, pl);
    endtask

    initial begin
        bit en_r, pol_r;
        void'($urandom(32'h1d5e_a7c3));
        model_step();
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1", "pwm_out", pwm_out, 1'b0);
        check("R1", "irq_pulse", irq_pulse, 1'b0);
        rst_n = 1'b1;
        model_step();
        // R9: direct writes while disabled
        cyc(0, 0, 1, 8'd6, 1, 8'd2, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R2, R3, R4: steady strobes
        run_ticks(40, 0);
        // R5, R6, R7: writes at several distances before a duty match
        for (int d = 0; d < 8; d++) begin
            cyc(1, 1, 0, 0, 1, 8'(1 + (d % 4)), 0);
            run_ticks(d, 0);
            run_ticks(15, 0);
        end
        // R8: rewrites back to back, then settle
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 1, 8'(i % 5), 0);
        run_ticks(30, 0);
        // R11: period change while running
        cyc(1, 1, 1, 8'd9, 0, 0, 0);
        run_ticks(30, 0);
        // R10: inverted polarity
        run_ticks(25, 1);
        // R9: stop mid-run with pending writes, then restart
        cyc(1, 1, 0, 0, 1, 8'd5, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        @(negedge clk);
        check("R9", "pwm_out idle", pwm_out, exp_level(1'b0, out_pol));
        check("R9", "irq idle", irq_pulse, 1'b0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        run_ticks(25, 1);
        // random phase
        en_r = 1; pol_r = 0;
        for (int i = 0; i < 6000; i++) begin
            bit t, pw, dw;
            bit [7:0] pd, dd;
            if ($urandom_range(0, 199) == 0) en_r = ~en_r;
            if ($urandom_range(0, 299) == 0) pol_r = ~pol_r;
            t  = ($urandom_range(0, 1) == 1);
            pw = ($urandom_range(0, 59) == 0);
            dw = ($urandom_range(0, 14) == 0);
            pd = 8'($urandom_range(2, 14));
            dd = 8'($urandom_range(0, 12));
            cyc(t, en_r, pw, pd, dw, dd, pol_r);
        end
        @(negedge clk);
        compare_outputs();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule